// File: doc/BRIEF.md
# Normalized Min-Sum Check-Node Unit

This block is the check-node processor of a layered min-sum LDPC decoder. In one step it takes up to eight signed 6-bit messages arriving from variable nodes, together with a mask that marks which of those edges the current check node actually uses. It returns one extrinsic message per edge. The value sent back on an edge is built only from the *other* connected edges.

The unit works in two passes of logic. It first finds the two smallest magnitudes, the position of the smallest and the combined sign parity. It then derives each outgoing message from those values and shrinks the magnitude by one of two correction rules. A mode input chooses the rule: scaling by 7/8, or subtracting a fixed offset. Results are captured in a single output register, so a message set presented with its valid strobe appears on the outputs one clock later and stays there until the next accepted set.

Because check nodes in the staircase part of the code have only two or three edges, edges that are not in use are internally treated as +31 magnitude with a positive sign, and their outputs are zero.

Top module: `cnuTop`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid` is 0 and every output message is 0.
- R2: A message set presented with `inValid`=1 is captured at that rising edge; `outValid` is 1 in exactly the following cycle. With `inValid`=0, `outValid` falls to 0 and `msgOut` holds its previous value.
- R3: An input of -32 (6'b100000) is treated as magnitude 31, not 0, and no output message is ever -32.
- R4: An edge whose `edgeMask` bit is 0 contributes magnitude 31 with a positive sign to the other edges, and its own output is 0.
- R5: The pre-correction magnitude for connected edge j is the smallest magnitude among all edges other than j. Equal minima on two edges give both of those edges that same value.
- R6: The output sign for connected edge j is the XOR of the sign bits (bit 5, 1 = negative) of all connected edges other than j. A zero magnitude is always sent as 0.
- R7: With `offsetSel`=0 (normalized mode) the magnitude m becomes m - (m >> 3), so 31 becomes 28 and 7 becomes 7.
- R8: With `offsetSel`=1 (offset mode) the magnitude m becomes m - 1, floored at 0.
- R9: Any mask pattern is handled, including degree 0, degree 1, the staircase degrees 2 and 3, and full degree 8. Message k occupies bits [6k+5:6k] of `msgIn` and `msgOut`, and `edgeMask` bit k applies to message k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Capture strobe for the current message set |
| offsetSel | input | 1 | 0 = normalized 7/8 scaling, 1 = offset-by-one correction |
| edgeMask | input | 8 | 1 = edge connected to this check node |
| msgIn | input | 48 | Eight 6-bit two's-complement variable-to-check messages |
| outValid | output | 1 | High the cycle after a capture |
| msgOut | output | 48 | Eight 6-bit two's-complement check-to-variable messages |

## Verification
A wrong minimum index or a wrong second minimum shows up as exactly one edge carrying the wrong magnitude. A faulty parity term flips the sign on every connected edge at once. A broken clamp for -32 turns a large input into a zero and drives every other edge's output toward zero. Each of these faults is visible in the cycle right after the capture strobe, so every random vector is compared against an independently computed extrinsic minimum and sign, in that cycle, for both correction modes. Directed cases cover ties, a single connected edge, an empty mask and all-negative full-degree sets.

// File: rtl/cnuPkg.sv
package cnuPkg;

  // Correction rule applied to the outgoing magnitude.
  typedef enum logic {
    MODE_NORM   = 1'b0,
    MODE_OFFSET = 1'b1
  } cnuMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;     // register a new result this edge
    logic offsetMode;  // use offset correction instead of scaling
  } cnuStrobe_t;

endpackage

// File: rtl/cnuCtrl.sv
module cnuCtrl
  import cnuPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       offsetSel,
  output cnuStrobe_t strobe,
  output logic       outValid
);

  cnuMode_e modeSel;

  always_comb begin
    modeSel           = cnuMode_e'(offsetSel);
    strobe.capture    = inValid;
    strobe.offsetMode = (modeSel == MODE_OFFSET);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/cnuDatapath.sv
module cnuDatapath
  import cnuPkg::*;
#(
  parameter int DEG        = 8,
  parameter int W          = 6,
  parameter int NORM_SHIFT = 3,
  parameter int OFFSET     = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnuStrobe_t       strobe,
  input  logic [DEG-1:0]   edgeMask,
  input  logic [DEG*W-1:0] msgIn,
  output logic [DEG*W-1:0] msgOut
);

  localparam int MW = W - 1;
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;
  localparam logic [MW-1:0] MAXMAG  = '1;
  localparam logic [W-1:0]  MOSTNEG = {1'b1, {MW{1'b0}}};
  localparam logic [MW-1:0] OFFS    = MW'(OFFSET);

  logic [MW-1:0] edgeMag  [DEG];
  logic          edgeSign [DEG];

  // Per-edge magnitude/sign extraction with saturation and masking.
  for (genvar g = 0; g < DEG; g++) begin : gExtract
    logic [W-1:0] raw;
    logic [W-1:0] negRaw;
    always_comb begin
      raw    = msgIn[g*W +: W];
      negRaw = -raw;
      if (!edgeMask[g]) begin
        edgeMag[g]  = MAXMAG;
        edgeSign[g] = 1'b0;
      end else if (raw == MOSTNEG) begin
        edgeMag[g]  = MAXMAG;
        edgeSign[g] = 1'b1;
      end else if (raw[W-1]) begin
        edgeMag[g]  = negRaw[MW-1:0];
        edgeSign[g] = 1'b1;
      end else begin
        edgeMag[g]  = raw[MW-1:0];
        edgeSign[g] = 1'b0;
      end
    end
  end

  // Two-minimum search and sign parity.
  logic [MW-1:0] min1, min2;
  logic [IW-1:0] minIdx;
  logic          parity;

  always_comb begin
    min1   = MAXMAG;
    min2   = MAXMAG;
    minIdx = '0;
    parity = 1'b0;
    for (int i = 0; i < DEG; i++) begin
      if (edgeMag[i] < min1) begin
        min2   = min1;
        min1   = edgeMag[i];
        minIdx = IW'(i);
      end else if (edgeMag[i] < min2) begin
        min2 = edgeMag[i];
      end
      parity = parity ^ edgeSign[i];
    end
  end

  // Per-edge extrinsic output, correction and register.
  for (genvar g = 0; g < DEG; g++) begin : gOutput
    logic [MW-1:0] selMag;
    logic [MW-1:0] corrMag;
    logic          outSign;
    logic [W-1:0]  nextMsg;
    always_comb begin
      selMag = (minIdx == IW'(g)) ? min2 : min1;
      if (strobe.offsetMode)
        corrMag = (selMag > OFFS) ? (selMag - OFFS) : '0;
      else
        corrMag = selMag - (selMag >> NORM_SHIFT);
      outSign = parity ^ edgeSign[g];
      if (!edgeMask[g])
        nextMsg = '0;
      else if (outSign)
        nextMsg = -{1'b0, corrMag};
      else
        nextMsg = {1'b0, corrMag};
    end

    always_ff @(posedge clk) begin
      if (!rstN)                msgOut[g*W +: W] <= '0;
      else if (strobe.capture)  msgOut[g*W +: W] <= nextMsg;
    end
  end

endmodule

// File: rtl/cnuTop.sv
module cnuTop
  import cnuPkg::*;
#(
  parameter int DEG        = 8,
  parameter int W          = 6,
  parameter int NORM_SHIFT = 3,
  parameter int OFFSET     = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             offsetSel,
  input  logic [DEG-1:0]   edgeMask,
  input  logic [DEG*W-1:0] msgIn,
  output logic             outValid,
  output logic [DEG*W-1:0] msgOut
);

  cnuStrobe_t strobe;

  cnuCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .offsetSel(offsetSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cnuDatapath #(
    .DEG       (DEG),
    .W         (W),
    .NORM_SHIFT(NORM_SHIFT),
    .OFFSET    (OFFSET)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .edgeMask(edgeMask),
    .msgIn   (msgIn),
    .msgOut  (msgOut)
  );

endmodule

// File: rtl/cnuChecker.sv
module cnuChecker #(
  parameter int DEG        = 8,
  parameter int W          = 6,
  parameter int NORM_SHIFT = 3,
  parameter int OFFSET     = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             offsetSel,
  input logic [DEG-1:0]   edgeMask,
  input logic [DEG*W-1:0] msgOut,
  input logic             outValid
);

  localparam int MAXMAG   = (1 << (W-1)) - 1;
  localparam int NORM_CAP = MAXMAG - (MAXMAG >> NORM_SHIFT);
  localparam int OFF_CAP  = (MAXMAG > OFFSET) ? (MAXMAG - OFFSET) : 0;
  localparam logic [W-1:0] MOSTNEG = {1'b1, {(W-1){1'b0}}};

  function automatic int magOf(logic [W-1:0] v);
    logic [W-1:0] n;
    n = -v;
    return v[W-1] ? int'(n) : int'(v);
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(msgOut));  // R2

  for (genvar g = 0; g < DEG; g++) begin : gEdge
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !edgeMask[g]) |=> (msgOut[g*W +: W] == '0));  // R4
    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
      msgOut[g*W +: W] != MOSTNEG);  // R3
    AST_NORM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !offsetSel) |=> (magOf(msgOut[g*W +: W]) <= NORM_CAP));  // R7
    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && offsetSel) |=> (magOf(msgOut[g*W +: W]) <= OFF_CAP));  // R8
  end

endmodule

bind cnuTop cnuChecker #(
  .DEG       (DEG),
  .W         (W),
  .NORM_SHIFT(NORM_SHIFT),
  .OFFSET    (OFFSET)
) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .offsetSel(offsetSel),
  .edgeMask (edgeMask),
  .msgOut   (msgOut),
  .outValid (outValid)
);

// File: tb/tb_cnuTop.sv
module tb_cnuTop;

  localparam int DEG = 8;
  localparam int W   = 6;
  localparam int NV  = 400;

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic             offsetSel;
  logic [DEG-1:0]   edgeMask;
  logic [DEG*W-1:0] msgIn;
  logic             outValid;
  logic [DEG*W-1:0] msgOut;

  int  checkCount = 0;
  int  errorCount = 0;
  bit  finished   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cnuTop #(.DEG(DEG), .W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .offsetSel(offsetSel),
    .edgeMask(edgeMask), .msgIn(msgIn), .outValid(outValid), .msgOut(msgOut)
  );

  // Expected outputs computed straight from the requirements.
  function automatic logic [DEG*W-1:0] refModel(logic [DEG*W-1:0] m,
                                                 logic [DEG-1:0] mk,
                                                 logic off);
    int mags[DEG];
    int sgns[DEG];
    logic [DEG*W-1:0] res;
    res = '0;
    for (int k = 0; k < DEG; k++) begin
      int v;
      v = int'($signed(m[k*W +: W]));
      if (!mk[k]) begin mags[k] = 31; sgns[k] = 0; end
      else if (v < 0) begin mags[k] = (v == -32) ? 31 : -v; sgns[k] = 1; end
      else begin mags[k] = v; sgns[k] = 0; end
    end
    for (int j = 0; j < DEG; j++) begin
      if (mk[j]) begin
        int best, sp, sc, outv;
        logic [31:0] tmp;
        best = 31; sp = 0;
        for (int k = 0; k < DEG; k++) begin
          if (k != j) begin
            if (mags[k] < best) best = mags[k];
            sp = sp ^ sgns[k];
          end
        end
        if (off) sc = (best > 1) ? best - 1 : 0;
        else     sc = best - (best / 8);
        outv = sp ? -sc : sc;
        tmp = outv;
        res[j*W +: W] = tmp[W-1:0];
      end
    end
    return res;
  endfunction

  task automatic check(string req, logic [DEG*W-1:0] act, logic [DEG*W-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      errorCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checkCount++;
    if (act !== exp) begin
      errorCount++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive one set, capture it, check in the cycle after capture.
  task automatic runVec(string req, logic [DEG*W-1:0] m, logic [DEG-1:0] mk, logic off);
    @(negedge clk);
    msgIn = m; edgeMask = mk; offsetSel = off; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit({req, " valid"}, outValid, 1'b1);
    check(req, msgOut, refModel(m, mk, off));
  endtask

  function automatic logic [DEG*W-1:0] packAll(int v);
    logic [DEG*W-1:0] r;
    logic [31:0] t;
    t = v;
    for (int k = 0; k < DEG; k++) r[k*W +: W] = t[W-1:0];
    return r;
  endfunction

  initial begin
    automatic logic [DEG*W-1:0] m;
    automatic logic [DEG*W-1:0] held;
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b1; offsetSel = 1'b0;
    edgeMask = '1; msgIn = packAll(5);
    repeat (3) @(negedge clk);
    checkBit("R1 reset valid", outValid, 1'b0);
    check("R1 reset msg", msgOut, '0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 after reset valid", outValid, 1'b0);
    check("R1 after reset msg", msgOut, '0);

    // R3: -32 saturates to 31
    m = packAll(20); m[2*W +: W] = 6'b100000;
    runVec("R3 most negative", m, 8'hFF, 1'b0);
    runVec("R3 all most negative", packAll(-32), 8'hFF, 1'b1);
    m = '0; m[0 +: W] = 6'b100000; m[W +: W] = 6'd9;
    runVec("R3 degree2 with -32", m, 8'h03, 1'b0);

    // R4: unconnected edges with tiny values must not win
    m = packAll(0); m[0 +: W] = 6'd12; m[W +: W] = 6'd20; m[2*W +: W] = 6'h3B;
    runVec("R4 masked zeros ignored", m, 8'h07, 1'b0);

    // R5: tie and distinct minima
    m = packAll(25); m[3*W +: W] = 6'd4; m[6*W +: W] = 6'h3C;
    runVec("R5 tie of minima", m, 8'hFF, 1'b1);
    m = packAll(25); m[1*W +: W] = 6'd2; m[5*W +: W] = 6'd17;
    runVec("R5 distinct minima", m, 8'hFF, 1'b0);

    // R6: all negative full degree
    runVec("R6 all negative", packAll(-9), 8'hFF, 1'b0);
    m = packAll(0); m[0 +: W] = 6'h3F; m[W +: W] = 6'd0;
    runVec("R6 zero magnitude sign", m, 8'h03, 1'b1);

    // R7 / R8: correction rules on known magnitudes
    m = '0; m[0 +: W] = 6'd31; m[W +: W] = 6'd7;
    runVec("R7 normalized scaling", m, 8'h03, 1'b0);
    runVec("R8 offset reduction", m, 8'h03, 1'b1);
    m = '0; m[0 +: W] = 6'd1; m[W +: W] = 6'd0;
    runVec("R8 offset floor", m, 8'h03, 1'b1);

    // R9: degree 0, 1 and staircase 2/3
    runVec("R9 degree zero", packAll(7), 8'h00, 1'b0);
    runVec("R9 degree one", packAll(-5), 8'h10, 1'b0);
    m = '0; m[4*W +: W] = 6'h37; m[6*W +: W] = 6'd14; m[7*W +: W] = 6'd3;
    runVec("R9 degree three", m, 8'hD0, 1'b1);

    // R2: hold while idle
    held = msgOut;
    @(negedge clk);
    msgIn = packAll(-1); edgeMask = 8'hFF;
    @(negedge clk);
    checkBit("R2 idle valid low", outValid, 1'b0);
    check("R2 hold while idle", msgOut, held);

    // Random sets over all masks and both modes (R5 R6 R7 R8 R9)
    for (int n = 0; n < NV; n++) begin
      automatic logic [DEG-1:0] mk;
      automatic logic off;
      for (int k = 0; k < DEG; k++) begin
        automatic int r = $urandom_range(0, 9);
        m[k*W +: W] = (r == 0) ? 6'b100000 : 6'($urandom);
      end
      case ($urandom_range(0, 3))
        0:       mk = 8'h03 << $urandom_range(0, 6);
        1:       mk = 8'h07 << $urandom_range(0, 5);
        2:       mk = 8'hFF;
        default: mk = 8'($urandom);
      endcase
      off = 1'($urandom);
      runVec("R5 R6 R7 R8 R9 random", m, mk, off);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checkCount, errorCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      errorCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checkCount, errorCount);
      $finish;
    end
  end

endmodule